// File: doc/BRIEF.md
# Peripheral Interrupt Status and Mask Controller

This block collects interrupt requests from a set of peripheral sources and keeps them in a status register. It also holds a mask register, and it raises one external-pending line towards the processor when a status bit and its mask bit are both set. Software reaches both registers through a simple memory-mapped register port. It clears a latched request by writing a word in which that bit is zero. The write is ANDed into the status, so bits written as one are left as they are.

The same block also holds the processor-side gating logic. The processor supplies its status word and its cause word. The block puts the external-pending line into cause bit 10. It decides whether an interrupt is taken from the global enable bit and the eight per-line enable bits in the status word. When an interrupt is taken, it returns the exception return address and the updated cause word. That cause word carries exception code 0 and a flag that says whether the interrupted instruction sat in a branch delay slot.

Top module: `intc_top`

## Requirements
- R1: After reset, both the status register and the mask register read as zero, and irqPending is low.
- R2: A read at address 0x1F801070 returns the status register in bits 10:0. A read at 0x1F801074 returns the mask register in bits 10:0. The upper bits read as zero, and any other address reads as zero. Read data is combinational from the current address.
- R3: A write to the status address replaces the status with (status AND write data) on the next clock. Bits written as 1 are left unchanged.
- R4: A write to the mask address stores write data bits 10:0 and discards the other bits.
- R5: A 0-to-1 transition of irqSrc[i], sampled on consecutive clocks, sets status bit i on that clock. A source held high sets the bit only once, so after it is acknowledged the bit stays clear.
- R6: If a rising edge on source i and a status write with bit i = 0 happen in the same clock, status bit i ends up set.
- R7: irqPending is high exactly when (status AND mask) is nonzero. It appears as bit 10 of causeOut, replacing cpuCause bit 10.
- R8: irqTake is high exactly when cpuStatus bit 0 is 1 and (cpuStatus AND effective cause AND 0xFF00) is nonzero. The effective cause is cpuCause with bit 10 replaced by irqPending.
- R9: While irqTake is high, causeOut bits 6:2 (exception code) are 0. While irqTake is low, causeOut equals the effective cause.
- R10: While irqTake is high, epcOut is curPc - 4 and causeOut bit 31 is 1 if inDelaySlot is set. Otherwise epcOut is curPc and causeOut bit 31 is 0. All other causeOut bits equal the effective cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Register port address |
| busWrEn | input | 1 | Register write strobe |
| busWData | input | 32 | Register write data |
| busRData | output | 32 | Register read data |
| irqSrc | input | 11 | Peripheral request levels |
| irqPending | output | 1 | Masked pending line to the processor |
| cpuStatus | input | 32 | Processor status word (bit 0 global enable, bits 15:8 line enables) |
| cpuCause | input | 32 | Processor cause word |
| curPc | input | 32 | Address of the instruction being interrupted |
| inDelaySlot | input | 1 | Interrupted instruction is in a branch delay slot |
| irqTake | output | 1 | Interrupt is taken this cycle |
| epcOut | output | 32 | Exception return address |
| causeOut | output | 32 | Updated cause word |

## Verification
Acknowledge writes are tried in several forms. A write of all ones shows that it changes nothing. A single zero bit against a source held high tells an edge detector apart from a level latch. An acknowledge in the same cycle as a fresh rise shows that set wins over clear. The gating is tried with the enable bit off, with the pending line as the only candidate and a line enable set or clear, and with a software cause bit alone. These show that bit 0 and each enable take part. Taken interrupts are tried both inside and outside a delay slot, which separates the two return-address forms. A long stretch of random sources, writes and processor words follows. Throughout, every cycle is compared with the bench model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef struct packed {
    logic statWr;
    logic maskWr;
    logic statSel;
    logic maskSel;
  } regStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h1F80_1070,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 32'h1F80_1074
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWrEn,
  output intc_pkg::regStrobe_t strobe
);
  logic hitStat;
  logic hitMask;

  always_comb begin
    hitStat = (busAddr == STAT_ADDR);
    hitMask = (busAddr == MASK_ADDR);
    strobe.statSel = hitStat;
    strobe.maskSel = hitMask;
    strobe.statWr = hitStat && busWrEn;
    strobe.maskWr = hitMask && busWrEn;
  end

  // R2: at most one register is ever selected
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.statSel, strobe.maskSel}));
  // R3, R4: a write strobe only follows an asserted bus write
  a_r3_write_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statWr || strobe.maskWr) |-> busWrEn);
endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int NUM_SRC = 11,
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  intc_pkg::regStrobe_t strobe,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic [NUM_SRC-1:0] irqSrc,
  output logic irqPending
);
  logic [NUM_SRC-1:0] statQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] prevSrc;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] wLow;

  assign wLow = busWData[NUM_SRC-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign riseVec[i] = irqSrc[i] && !prevSrc[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ[i] <= 1'b0;
        maskQ[i] <= 1'b0;
        prevSrc[i] <= 1'b0;
      end else begin
        prevSrc[i] <= irqSrc[i];
        if (riseVec[i]) statQ[i] <= 1'b1;
        else if (strobe.statWr) statQ[i] <= statQ[i] && wLow[i];
        if (strobe.maskWr) maskQ[i] <= wLow[i];
      end
    end
  end

  always_comb begin
    busRData = '0;
    if (strobe.statSel) busRData[NUM_SRC-1:0] = statQ;
    else if (strobe.maskSel) busRData[NUM_SRC-1:0] = maskQ;
  end

  assign irqPending = |(statQ & maskQ);

  // R3: after a status write, no bit is set that was neither kept nor newly raised
  a_r3_and_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.statWr |=> ((statQ & ~(($past(statQ) & $past(wLow)) | $past(riseVec))) == '0));
  // R5: without a write, status only gains bits from rising edges
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.statWr |=> ((statQ & ~($past(statQ) | $past(riseVec))) == '0));
  // R6: a rising edge always lands, even against a clearing write
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|riseVec) |=> ((statQ & $past(riseVec)) == $past(riseVec)));
  // R4: the mask captures the low write bits
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskWr |=> (maskQ == $past(wLow)));
endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
  parameter int DATA_W = 32,
  parameter int INSTR_BYTES = 4,
  parameter int PEND_BIT = 10,
  parameter int BD_BIT = 31
) (
  input  logic clk,
  input  logic rstN,
  input  logic irqPending,
  input  logic [DATA_W-1:0] cpuStatus,
  input  logic [DATA_W-1:0] cpuCause,
  input  logic [DATA_W-1:0] curPc,
  input  logic inDelaySlot,
  output logic irqTake,
  output logic [DATA_W-1:0] epcOut,
  output logic [DATA_W-1:0] causeOut
);
  localparam logic [DATA_W-1:0] LINE_MASK = DATA_W'(32'h0000_FF00);
  localparam int CODE_LO = 2;
  localparam int CODE_HI = 6;

  logic [DATA_W-1:0] effCause;

  always_comb begin
    effCause = cpuCause;
    effCause[PEND_BIT] = irqPending;
    irqTake = cpuStatus[0] && ((cpuStatus & effCause & LINE_MASK) != '0);
    epcOut = inDelaySlot ? (curPc - DATA_W'(INSTR_BYTES)) : curPc;
    causeOut = effCause;
    if (irqTake) begin
      causeOut[CODE_HI:CODE_LO] = '0;
      causeOut[BD_BIT] = inDelaySlot;
    end
  end

  // R8: the global enable must be on for a take
  a_r8_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
    !cpuStatus[0] |-> !irqTake);
  // R7: the pending line reaches cause bit 10
  a_r7_pend_in_cause: assert property (@(posedge clk) disable iff (!rstN)
    causeOut[PEND_BIT] == irqPending);
  // R9: a taken interrupt carries exception code 0
  a_r9_code_zero: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (causeOut[CODE_HI:CODE_LO] == '0));
  // R10: branch-delay flag follows the slot input on a take
  a_r10_bd_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (causeOut[BD_BIT] == inDelaySlot));
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int NUM_SRC = 11,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h1F80_1070,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 32'h1F80_1074
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic busWrEn,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  input  logic [NUM_SRC-1:0] irqSrc,
  output logic irqPending,
  input  logic [DATA_W-1:0] cpuStatus,
  input  logic [DATA_W-1:0] cpuCause,
  input  logic [DATA_W-1:0] curPc,
  input  logic inDelaySlot,
  output logic irqTake,
  output logic [DATA_W-1:0] epcOut,
  output logic [DATA_W-1:0] causeOut
);
  intc_pkg::regStrobe_t strobe;

  intc_ctrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe));

  intc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWData(busWData),
    .busRData(busRData), .irqSrc(irqSrc), .irqPending(irqPending));

  intc_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .cpuStatus(cpuStatus),
    .cpuCause(cpuCause), .curPc(curPc), .inDelaySlot(inDelaySlot),
    .irqTake(irqTake), .epcOut(epcOut), .causeOut(causeOut));
endmodule

// File: tb/intc_top_test.sv
module intc_top_test;
  localparam logic [31:0] SA = 32'h1F80_1070;
  localparam logic [31:0] MA = 32'h1F80_1074;

  logic clk = 0;
  logic rstN = 0;
  logic [31:0] busAddr = 0;
  logic busWrEn = 0;
  logic [31:0] busWData = 0;
  logic [31:0] busRData;
  logic [10:0] irqSrc = 0;
  logic irqPending;
  logic [31:0] cpuStatus = 0;
  logic [31:0] cpuCause = 0;
  logic [31:0] curPc = 0;
  logic inDelaySlot = 0;
  logic irqTake;
  logic [31:0] epcOut;
  logic [31:0] causeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mStat = 0;
  logic [31:0] mMask = 0;
  logic [31:0] mPrev = 0;

  intc_top uut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // reference model state update
  always @(posedge clk) begin
    if (!rstN) begin
      mStat = 0; mMask = 0; mPrev = 0;
    end else begin
      if (busWrEn && busAddr == SA) mStat = mStat & busWData & 32'h7FF;
      mStat = mStat | ({21'b0, irqSrc} & ~mPrev);
      if (busWrEn && busAddr == MA) mMask = busWData & 32'h7FF;
      mPrev = {21'b0, irqSrc};
    end
  end

  // every-cycle comparison, away from the edge
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      logic pend, take;
      logic [31:0] eff, expRd, expCause;
      pend = (mStat & mMask) != 0;
      eff = cpuCause;
      eff[10] = pend;
      take = cpuStatus[0] && ((cpuStatus & eff & 32'hFF00) != 0);
      expRd = (busAddr == SA) ? mStat : (busAddr == MA) ? mMask : 32'h0;
      expCause = eff;
      if (take) begin
        expCause[6:2] = 5'b0;
        expCause[31] = inDelaySlot;
      end
      check("R7 pending", {31'b0, irqPending}, {31'b0, pend});
      check("R2 read", busRData, expRd);
      check("R8 take", {31'b0, irqTake}, {31'b0, take});
      check("R9 cause", causeOut, expCause);
      if (take) check("R10 epc", epcOut, inDelaySlot ? curPc - 4 : curPc);
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0; busWData = 0;
  endtask

  task automatic rdCheck(input string req, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #2;
    check(req, busRData, exp);
  endtask

  task automatic cpuCheck(input string req, input logic [31:0] st, input logic [31:0] ca,
                          input logic ds, input logic expTake, input logic [31:0] expEpc);
    @(negedge clk);
    cpuStatus = st; cpuCause = ca; inDelaySlot = ds; curPc = 32'h8001_0010;
    #2;
    check(req, {31'b0, irqTake}, {31'b0, expTake});
    if (expTake) check(req, epcOut, expEpc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1
    rdCheck("R1 status reset", SA, 0);
    rdCheck("R1 mask reset", MA, 0);
    check("R1 pending reset", {31'b0, irqPending}, 0);
    rdCheck("R2 other address", 32'h1F80_1078, 0);
    // R4
    wr(MA, 32'hFFFF_FFFF);
    rdCheck("R4 mask truncated", MA, 32'h7FF);
    // R5
    @(negedge clk); irqSrc = 11'h005;
    rdCheck("R5 edges set", SA, 32'h005);
    wr(SA, 32'hFFFF_FFFE);
    rdCheck("R5 held level no reset", SA, 32'h004);
    // R3
    wr(SA, 32'hFFFF_FFFF);
    rdCheck("R3 ones keep", SA, 32'h004);
    // R6
    @(negedge clk); irqSrc = 11'h001;
    @(negedge clk);
    busAddr = SA; busWData = 32'h0; busWrEn = 1; irqSrc = 11'h005;
    @(negedge clk); busWrEn = 0;
    rdCheck("R6 set wins", SA, 32'h004);
    // R8 / R10 with pending = 1
    cpuCheck("R8 global off", 32'h0000_0400, 0, 0, 0, 0);
    cpuCheck("R8 line enable off", 32'h0000_0001, 0, 0, 0, 0);
    cpuCheck("R10 take no slot", 32'h0000_0401, 0, 0, 1, 32'h8001_0010);
    cpuCheck("R10 take in slot", 32'h0000_0401, 32'h0000_007C, 1, 1, 32'h8001_000C);
    wr(SA, 32'h0);
    cpuCheck("R8 no pending", 32'h0000_0401, 0, 0, 0, 0);
    cpuCheck("R8 software bit", 32'h0000_0101, 32'h0000_0100, 1, 1, 32'h8001_000C);
    // random stretch
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      irqSrc = 11'($urandom);
      busAddr = ($urandom % 3 == 0) ? SA : ($urandom % 2 == 0) ? MA : 32'h1F80_1000;
      busWrEn = ($urandom % 4 == 0);
      busWData = $urandom;
      cpuStatus = $urandom & 32'h0000_FF01;
      cpuCause = $urandom;
      curPc = $urandom & 32'hFFFF_FFFC;
      inDelaySlot = 1'($urandom);
    end
    @(negedge clk); busWrEn = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule